// File: doc/BRIEF.md
# Phase-Frequency Detector with Digital Lock Detect

This block compares two divided pulse trains, a reference train and a feedback train, in the domain of a fast system clock. Rising edges on each input set a flag. The reference flag drives an active-low pump-up output. The feedback flag drives an active-low pump-down output. When both flags are set, both are cleared together on the next clock. The outputs therefore show a pulse only on the side whose edge arrived first. When the edges coincide, both sides show only a one-cycle reset glitch.

A raw lock-activity signal is the NAND of the two active-low pump outputs. It is high whenever either pump is active. A digital persistence filter replaces the usual capacitor smoothing. The filter counts consecutive comparisons in which the leading side stayed alone for no more than `LEAD_TOL` clock cycles. It raises the lock output once `LOCK_COUNT` such comparisons have been seen in a row. If one side stays alone for longer than that, lock is withdrawn at once, without waiting for the comparison to finish.

Top module: `pfd_lock_detect`

## Requirements
- R1: While rst_ni is low, up_no and dn_no are 1, and lock_o and lock_raw_o are 0.
- R2: An input rising edge set up before clock edge E0 makes the matching pump output go low right after edge E2. This is a latency of three clock edges (default SYNC_STAGES = 2).
- R3: When the reference edge leads the feedback edge by k cycles, up_no is low for k+1 cycles and dn_no is low for 1 cycle.
- R4: When the feedback edge leads the reference edge by k cycles, dn_no is low for k+1 cycles and up_no is low for 1 cycle.
- R5: Edges on both inputs in the same cycle give exactly one cycle in which both outputs are low. Both outputs low never lasts two cycles, and the two outputs return high at the same edge.
- R6: lock_raw_o equals NAND(up_no, dn_no) in every cycle.
- R7: Only rising edges act. Holding an input high, or a falling edge, produces no pump pulse.
- R8: lock_o goes to 1 after LOCK_COUNT consecutive comparisons whose lead is at most LEAD_TOL cycles (defaults 4 and 2). It rises at the edge where the last of them clears both pumps.
- R9: Once exactly one pump has been low for LEAD_TOL+1 consecutive cycles, lock_o is 0 from the next edge. That comparison does not count toward lock, and the consecutive count restarts.

Ports follow the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Divided reference pulse train |
| fb_i | input | 1 | Divided feedback pulse train |
| up_no | output | 1 | Pump-up, active low; low while the reference leads |
| dn_no | output | 1 | Pump-down, active low; low while the feedback leads |
| lock_raw_o | output | 1 | NAND of the two pump outputs |
| lock_o | output | 1 | Filtered lock indication, 1 when locked |

## Verification
The following properties are checked on every cycle:
- the idle state of the pumps in reset;
- the single-cycle limit on both pumps being low together;
- the two pumps releasing at the same edge;
- quiet pumps at the moment lock rises;
- lock being withdrawn once a one-sided run exceeds the tolerance.

Other behaviours can only be shown by the bench's scenarios:
- the exact pulse widths for each lead and direction;
- the three-edge input latency;
- the count of good comparisons needed before lock rises;
- the absence of pulses on held or falling inputs.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;
endpackage

// File: rtl/pfd_edge_sync.sv
`timescale 1ns/1ps
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_flags.sv
`timescale 1ns/1ps
module pfd_flags
  import pfd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rise_ref_i,
  input  logic  rise_fb_i,
  output pump_t flags_o,
  output logic  clear_o
);
  pump_t flags_q, flags_d;

  assign clear_o = flags_q.up & flags_q.dn;

  // clear wins: an edge landing in the clear cycle is dropped
  always_comb begin
    if (clear_o) begin
      flags_d = '0;
    end else begin
      flags_d.up = flags_q.up | rise_ref_i;
      flags_d.dn = flags_q.dn | rise_fb_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pfd_lock_filter.sv
`timescale 1ns/1ps
module pfd_lock_filter
  import pfd_pkg::*;
#(
  parameter int unsigned LOCK_COUNT = 4,
  parameter int unsigned LEAD_TOL   = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pump_t flags_i,
  input  logic  clear_i,
  output logic  lock_o
);
  localparam int unsigned LCW = $clog2(LOCK_COUNT + 1);
  localparam int unsigned SCW = $clog2(LEAD_TOL + 2);
  localparam logic [LCW-1:0] LOCK_MAX = LCW'(LOCK_COUNT);
  localparam logic [SCW-1:0] SIDE_MAX = SCW'(LEAD_TOL);

  logic [LCW-1:0] lock_cnt_q;
  logic [SCW-1:0] side_cnt_q;
  logic           spoiled_q;
  logic           one_sided, too_long;

  assign one_sided = flags_i.up ^ flags_i.dn;
  assign too_long  = one_sided && (side_cnt_q == SIDE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_cnt_q <= '0;
    end else if (!one_sided) begin
      side_cnt_q <= '0;
    end else if (side_cnt_q != SIDE_MAX) begin
      side_cnt_q <= side_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       spoiled_q <= 1'b0;
    else if (clear_i)  spoiled_q <= 1'b0;
    else if (too_long) spoiled_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_cnt_q <= '0;
    end else if (too_long) begin
      lock_cnt_q <= '0;
    end else if (clear_i) begin
      if (spoiled_q)                  lock_cnt_q <= '0;
      else if (lock_cnt_q != LOCK_MAX) lock_cnt_q <= lock_cnt_q + 1'b1;
    end
  end

  assign lock_o = (lock_cnt_q == LOCK_MAX);
endmodule

// File: rtl/pfd_lock_detect.sv
`timescale 1ns/1ps
module pfd_lock_detect
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOCK_COUNT  = 4,
  parameter int unsigned LEAD_TOL    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_no,
  output logic dn_no,
  output logic lock_raw_o,
  output logic lock_o
);
  logic [NUM_CH-1:0] in_vec, rise_vec;
  pump_t             flags;
  logic              clear;

  assign in_vec[CH_REF] = ref_i;
  assign in_vec[CH_FB]  = fb_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (in_vec[c]),
      .rise_o (rise_vec[c])
    );
  end

  pfd_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_ref_i (rise_vec[CH_REF]),
    .rise_fb_i  (rise_vec[CH_FB]),
    .flags_o    (flags),
    .clear_o    (clear)
  );

  pfd_lock_filter #(.LOCK_COUNT(LOCK_COUNT), .LEAD_TOL(LEAD_TOL)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags),
    .clear_i (clear),
    .lock_o  (lock_o)
  );

  assign up_no      = ~flags.up;
  assign dn_no      = ~flags.dn;
  assign lock_raw_o = flags.up | flags.dn;
endmodule

// File: rtl/pfd_lock_detect_chk.sv
`timescale 1ns/1ps
module pfd_lock_detect_chk #(
  parameter int unsigned LEAD_TOL = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic up_no,
  input logic dn_no,
  input logic lock_o
);
  localparam int unsigned RCW = $clog2(LEAD_TOL + 3);
  localparam logic [RCW-1:0] RUN_LIM = RCW'(LEAD_TOL + 1);

  logic [RCW-1:0] run_q;
  logic           lone;

  assign lone = up_no ^ dn_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (!lone)            run_q <= '0;
    else if (run_q != RUN_LIM) run_q <= run_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (up_no && dn_no && !lock_o);
    end
  end

  p_glitch_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_no && !dn_no) |=> (up_no && dn_no));

  p_up_release_together_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_no) |-> dn_no);

  p_dn_release_together_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_no) |-> up_no);

  p_lock_rise_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (up_no && dn_no));

  p_long_lead_unlocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == RUN_LIM) |-> !lock_o);
endmodule

bind pfd_lock_detect pfd_lock_detect_chk #(.LEAD_TOL(LEAD_TOL)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .up_no  (up_no),
  .dn_no  (dn_no),
  .lock_o (lock_o)
);

// File: tb/pfd_lock_detect_test.sv
`timescale 1ns/1ps
module pfd_lock_detect_test;
  localparam int LOCK_COUNT = 4;
  localparam int LEAD_TOL   = 2;

  typedef struct {
    int    width;
    string tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic ref_i = 1'b0;
  logic fb_i  = 1'b0;
  logic up_no, dn_no, lock_raw_o, lock_o;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cons  = 0;
  bit   done  = 1'b0;
  exp_t up_exp[$];
  exp_t dn_exp[$];
  int   up_run = 0;
  int   dn_run = 0;

  always #2.5 clk_i = ~clk_i;

  pfd_lock_detect #(.SYNC_STAGES(2), .LOCK_COUNT(LOCK_COUNT), .LEAD_TOL(LEAD_TOL)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .up_no(up_no), .dn_no(dn_no), .lock_raw_o(lock_raw_o), .lock_o(lock_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit is_up, input int w, input string tag);
    exp_t e;
    e.width = w;
    e.tag   = tag;
    if (is_up) up_exp.push_back(e);
    else       dn_exp.push_back(e);
  endtask

  task automatic pop_cmp(input bit is_up, input int w);
    exp_t e;
    if (is_up ? (up_exp.size() == 0) : (dn_exp.size() == 0)) begin
      check(1'b0, is_up ? "R7 unexpected up pulse width" : "R7 unexpected dn pulse width", w, 0);
    end else begin
      e = is_up ? up_exp.pop_front() : dn_exp.pop_front();
      check(w == e.width, e.tag, w, e.width);
    end
  endtask

  // monitor: measures low runs and compares with the queued expectations
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && !done) begin
      check(lock_raw_o == ~(up_no & dn_no), "R6 raw lock", int'(lock_raw_o), int'(~(up_no & dn_no)));
      if (!up_no) up_run++;
      else if (up_run > 0) begin pop_cmp(1'b1, up_run); up_run = 0; end
      if (!dn_no) dn_run++;
      else if (dn_run > 0) begin pop_cmp(1'b0, dn_run); dn_run = 0; end
    end
  end

  task automatic compare(input bit ref_first, input int k, input bit chk_lat);
    bit    was_locked = lock_o;
    string lead_tag   = ref_first ? "R3 lead width" : "R4 lead width";
    string lag_tag    = ref_first ? "R3 lag width" : "R4 lag width";
    @(negedge clk_i);
    if (k == 0) begin
      ref_i = 1'b1;
      fb_i  = 1'b1;
      push(1'b1, 1, "R5 coincident up");
      push(1'b0, 1, "R5 coincident dn");
    end else begin
      if (ref_first) ref_i = 1'b1; else fb_i = 1'b1;
      push(ref_first,  k + 1, lead_tag);
      push(!ref_first, 1,     lag_tag);
    end
    for (int i = 1; i <= k; i++) begin
      @(negedge clk_i);
      if (chk_lat && ref_first && i == 2) check(up_no == 1'b1, "R2 latency early", int'(up_no), 1);
      if (chk_lat && ref_first && i == 3) check(up_no == 1'b0, "R2 latency", int'(up_no), 0);
      if (was_locked && k > LEAD_TOL && i == 3 + LEAD_TOL)
        check(lock_o == 1'b1, "R9 lock kept within tolerance", int'(lock_o), 1);
      if (was_locked && k > LEAD_TOL && i == 4 + LEAD_TOL)
        check(lock_o == 1'b0, "R9 lock dropped on long lead", int'(lock_o), 0);
    end
    if (ref_first) fb_i = 1'b1; else ref_i = 1'b1;
    repeat (3) @(negedge clk_i);
    ref_i = 1'b0;
    fb_i  = 1'b0;
    repeat (6) @(negedge clk_i);
    if (k <= LEAD_TOL) cons++; else cons = 0;
    check(lock_o == (cons >= LOCK_COUNT), "R8 lock after comparison", int'(lock_o),
          int'(cons >= LOCK_COUNT));
  endtask

  task automatic hold_test();
    @(negedge clk_i);
    ref_i = 1'b1;
    fb_i  = 1'b1;
    push(1'b1, 1, "R5 coincident up");
    push(1'b0, 1, "R5 coincident dn");
    repeat (6) @(negedge clk_i);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      check(up_no && dn_no, "R7 held high", int'({up_no, dn_no}), 3);
    end
    ref_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check(up_no && dn_no, "R7 ref falling", int'({up_no, dn_no}), 3);
    end
    fb_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check(up_no && dn_no, "R7 fb falling", int'({up_no, dn_no}), 3);
    end
    cons++;
    check(lock_o == (cons >= LOCK_COUNT), "R8 lock after hold", int'(lock_o),
          int'(cons >= LOCK_COUNT));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(up_no == 1'b1, "R1 up in reset", int'(up_no), 1);
    check(dn_no == 1'b1, "R1 dn in reset", int'(dn_no), 1);
    check(lock_o == 1'b0, "R1 lock in reset", int'(lock_o), 0);
    check(lock_raw_o == 1'b0, "R1 raw in reset", int'(lock_raw_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    compare(1'b1, 5, 1'b1);
    hold_test();
    compare(1'b1, 0, 1'b0);
    compare(1'b0, 1, 1'b0);
    compare(1'b1, 2, 1'b0);
    compare(1'b1, 6, 1'b0);
    compare(1'b0, 3, 1'b0);
    compare(1'b0, 2, 1'b0);
    compare(1'b1, 1, 1'b0);
    compare(1'b0, 0, 1'b0);
    compare(1'b0, 2, 1'b0);
    compare(1'b0, 7, 1'b0);

    repeat (5) @(negedge clk_i);
    check(up_exp.size() == 0, "R3 missing up pulses", up_exp.size(), 0);
    check(dn_exp.size() == 0, "R4 missing dn pulses", dn_exp.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R8 run incomplete actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule